// File: doc/BRIEF.md
# Auto-Acknowledging Priority Interrupt Controller

The controller collects a parameterized set of level-sensitive interrupt lines and routes them to a small number of processors. Each source has three pieces of state: a mask bit, a software trigger bit and a routing field that selects which processors see the source. A source counts as a request when its line is high or its software bit is set. It is pending for a processor when that request is present, its mask is clear and the processor is in its routing field.

Each processor also owns two inter-processor flags, a "self" flag and an "other" flag. Each flag has its own mask. A processor services interrupts by reading its event register. The read returns the highest-priority pending item, which means the IPI flags first and then the lowest-numbered source. In the same clock edge the read masks that item, so acknowledging it needs no separate write. Software unmasks the item once it has handled it.

Accesses use a simple single-cycle register port. The accessing processor's index comes with each access, so every processor reaches its own event register, IPI registers and identity register through the same addresses. Read data appears on the cycle after the request.

Top module: `autoack_intc`

## Requirements
- R1: After reset every source mask bit is 1, every software bit is 0, every routing field is 1 (processor 0 only), all IPI flags are 0, all IPI masks are 1 and every interrupt output is 0.
- R2: The request of source s is the OR of its input line and its software bit. Word w at address 0x000+w returns the raw input levels of sources 32w..32w+31, with source 32w+b at bit b. A source whose mask is set is never reported.
- R3: Writing word w at 0x010+w sets the mask bits of the sources whose write-data bits are 1. Writing it at 0x020+w clears them. Bits written as 0 leave their mask unchanged. Both addresses read back the current mask word.
- R4: Software bits behave the same way: 0x030+w sets, 0x040+w clears, and both addresses read back the current software word.
- R5: A read of the event register (0x200) that finds no IPI pending returns {16'd1, s}, where s is the lowest-numbered source pending for the accessing processor.
- R6: The event read that returns source s sets the mask bit of s in the same edge. A following event read therefore returns the next pending source.
- R7: The routing field of source s is at 0x100+s, with bit c selecting processor c. A source is reported to, and raises the interrupt output of, only the processors selected in its field.
- R8: For the accessing processor, writing bit 0 at 0x201 sets its self flag, and writing 0x202 sets the other flag of each processor c whose data bit c is 1. At 0x203, write-one clears the flags (bit 0 = self, bit 1 = other) and a read returns them. 0x204 sets and 0x205 clears the IPI masks, and both read them back. A flag that is set and unmasked is reported before any source, as {16'd4, 0} for self and then {16'd4, 1} for other.
- R9: An event read that reports an IPI sets that IPI's mask bit and leaves its flag set.
- R10: An event read with nothing pending returns 0 and changes no mask.
- R11: A read of 0x206 returns the index of the accessing processor.
- R12: Interrupt output c is the registered OR of everything pending for processor c. It rises one cycle after a change makes an item pending, and it falls one cycle after an acknowledging read removes the last pending item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | N_SRC | Level-sensitive interrupt lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Word address |
| wdata_i | input | 32 | Write data |
| cpu_i | input | CPU_W | Index of the accessing processor |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | N_CPU | Interrupt output per processor |

## Verification
The assertions check the following on every cycle:
- that a reported source has its mask set immediately after the read;
- that an empty event read leaves every mask untouched;
- that event words carry only legal type and number values;
- that each interrupt output follows its pending state one cycle later.

Some behaviours can only be shown by the bench's scenarios, because they depend on sequences of accesses:
- lowest-index priority between several sources;
- IPI-before-source ordering;
- routing to one processor and not the other;
- set-only and clear-only semantics of the paired registers;
- the exact reset values.

// File: rtl/autoack_intc_pkg.sv
package autoack_intc_pkg;
  localparam int unsigned ADDR_W = 12;

  typedef enum logic [15:0] {
    EV_NONE = 16'd0,
    EV_HW   = 16'd1,
    EV_IPI  = 16'd4
  } ev_type_e;

  localparam logic [ADDR_W-1:0] A_HWST      = 12'h000;
  localparam logic [ADDR_W-1:0] A_MSET      = 12'h010;
  localparam logic [ADDR_W-1:0] A_MCLR      = 12'h020;
  localparam logic [ADDR_W-1:0] A_SSET      = 12'h030;
  localparam logic [ADDR_W-1:0] A_SCLR      = 12'h040;
  localparam logic [ADDR_W-1:0] A_TGT       = 12'h100;
  localparam logic [ADDR_W-1:0] A_EVENT     = 12'h200;
  localparam logic [ADDR_W-1:0] A_IPI_SELF  = 12'h201;
  localparam logic [ADDR_W-1:0] A_IPI_OTHER = 12'h202;
  localparam logic [ADDR_W-1:0] A_IPI_ACK   = 12'h203;
  localparam logic [ADDR_W-1:0] A_IPI_MSET  = 12'h204;
  localparam logic [ADDR_W-1:0] A_IPI_MCLR  = 12'h205;
  localparam logic [ADDR_W-1:0] A_WHOAMI    = 12'h206;

  function automatic logic [31:0] ev_word(ev_type_e t, logic [15:0] n);
    return {t, n};
  endfunction
endpackage

// File: rtl/autoack_intc_prio.sv
module autoack_intc_prio #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // scan downward so the lowest set index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/autoack_intc_src_bank.sv
module autoack_intc_src_bank #(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_CPU = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_SRC-1:0]                  src_i,
  input  logic [N_SRC-1:0]                  mask_set_i,
  input  logic [N_SRC-1:0]                  mask_clr_i,
  input  logic [N_SRC-1:0]                  sw_set_i,
  input  logic [N_SRC-1:0]                  sw_clr_i,
  input  logic [N_SRC-1:0]                  ack_i,
  input  logic [N_SRC-1:0]                  tgt_we_i,
  input  logic [N_CPU-1:0]                  tgt_data_i,
  output logic [N_SRC-1:0]                  mask_o,
  output logic [N_SRC-1:0]                  sw_o,
  output logic [N_SRC-1:0][N_CPU-1:0]       tgt_o,
  output logic [N_CPU-1:0][N_SRC-1:0]       pend_o
);
  logic [N_SRC-1:0] mask_q, sw_q, req_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else begin
      mask_q <= (mask_q & ~mask_clr_i) | mask_set_i | ack_i;
      sw_q   <= (sw_q & ~sw_clr_i) | sw_set_i;
    end
  end

  assign req_eff = src_i | sw_q;

  for (genvar s = 0; s < N_SRC; s++) begin : g_tgt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           tgt_o[s] <= N_CPU'(1);
      else if (tgt_we_i[s])  tgt_o[s] <= tgt_data_i;
    end
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_pend
    for (genvar s = 0; s < N_SRC; s++) begin : g_bit
      assign pend_o[c][s] = req_eff[s] & ~mask_q[s] & tgt_o[s][c];
    end
  end

  assign mask_o = mask_q;
  assign sw_o   = sw_q;
endmodule

// File: rtl/autoack_intc_ipi_bank.sv
module autoack_intc_ipi_bank #(
  parameter int unsigned N_CPU = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CPU-1:0]      self_set_i,
  input  logic [N_CPU-1:0]      other_set_i,
  input  logic [N_CPU-1:0][1:0] ack_i,
  input  logic [N_CPU-1:0][1:0] mset_i,
  input  logic [N_CPU-1:0][1:0] mclr_i,
  input  logic [N_CPU-1:0][1:0] auto_mask_i,
  output logic [N_CPU-1:0][1:0] flag_o,
  output logic [N_CPU-1:0][1:0] mask_o,
  output logic [N_CPU-1:0][1:0] pend_o
);
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [1:0] flag_q, mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q <= 2'b00;
        mask_q <= 2'b11;
      end else begin
        flag_q <= (flag_q & ~ack_i[c]) | {other_set_i[c], self_set_i[c]};
        mask_q <= (mask_q & ~mclr_i[c]) | mset_i[c] | auto_mask_i[c];
      end
    end
    assign flag_o[c] = flag_q;
    assign mask_o[c] = mask_q;
    assign pend_o[c] = flag_q & ~mask_q;
  end
endmodule

// File: rtl/autoack_intc.sv
module autoack_intc
  import autoack_intc_pkg::*;
#(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_CPU = 2,
  localparam int unsigned CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [CPU_W-1:0]  cpu_i,
  output logic [31:0]       rdata_o,
  output logic [N_CPU-1:0]  irq_o
);
  localparam int unsigned N_WORDS = (N_SRC + 31) / 32;
  localparam int unsigned PAD_W   = N_WORDS * 32;
  localparam int unsigned IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic wr, rd, evt_rd;
  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign evt_rd = rd && (addr_i == A_EVENT);

  // word-level decode of the paired set/clear banks
  logic [PAD_W-1:0] mset_w, mclr_w, sset_w, sclr_w;
  logic [N_SRC-1:0] tgt_we;
  always_comb begin
    mset_w = '0;
    mclr_w = '0;
    sset_w = '0;
    sclr_w = '0;
    for (int w = 0; w < int'(N_WORDS); w++) begin
      if (wr && addr_i == A_MSET + 12'(w)) mset_w[w*32 +: 32] = wdata_i;
      if (wr && addr_i == A_MCLR + 12'(w)) mclr_w[w*32 +: 32] = wdata_i;
      if (wr && addr_i == A_SSET + 12'(w)) sset_w[w*32 +: 32] = wdata_i;
      if (wr && addr_i == A_SCLR + 12'(w)) sclr_w[w*32 +: 32] = wdata_i;
    end
    for (int s = 0; s < int'(N_SRC); s++)
      tgt_we[s] = wr && (addr_i == A_TGT + 12'(s));
  end

  logic [N_SRC-1:0]                src_mask, src_sw, hw_ack;
  logic [N_SRC-1:0][N_CPU-1:0]     src_tgt;
  logic [N_CPU-1:0][N_SRC-1:0]     src_pend;

  autoack_intc_src_bank #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (irq_src_i),
    .mask_set_i (mset_w[N_SRC-1:0]),
    .mask_clr_i (mclr_w[N_SRC-1:0]),
    .sw_set_i   (sset_w[N_SRC-1:0]),
    .sw_clr_i   (sclr_w[N_SRC-1:0]),
    .ack_i      (hw_ack),
    .tgt_we_i   (tgt_we),
    .tgt_data_i (wdata_i[N_CPU-1:0]),
    .mask_o     (src_mask),
    .sw_o       (src_sw),
    .tgt_o      (src_tgt),
    .pend_o     (src_pend)
  );

  logic [N_CPU-1:0]      ipi_self_set, ipi_other_set;
  logic [N_CPU-1:0][1:0] ipi_ack, ipi_mset, ipi_mclr, ipi_auto;
  logic [N_CPU-1:0][1:0] ipi_flag, ipi_mask, ipi_pend;
  logic [1:0]            ipi_sel;

  for (genvar c = 0; c < N_CPU; c++) begin : g_ipi_dec
    logic me;
    assign me               = (cpu_i == CPU_W'(c));
    assign ipi_self_set[c]  = wr && me && addr_i == A_IPI_SELF && wdata_i[0];
    assign ipi_other_set[c] = wr && addr_i == A_IPI_OTHER && wdata_i[c];
    assign ipi_ack[c]       = (wr && me && addr_i == A_IPI_ACK)  ? wdata_i[1:0] : 2'b00;
    assign ipi_mset[c]      = (wr && me && addr_i == A_IPI_MSET) ? wdata_i[1:0] : 2'b00;
    assign ipi_mclr[c]      = (wr && me && addr_i == A_IPI_MCLR) ? wdata_i[1:0] : 2'b00;
    assign ipi_auto[c]      = (evt_rd && me) ? ipi_sel : 2'b00;
  end

  autoack_intc_ipi_bank #(.N_CPU(N_CPU)) u_ipi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .self_set_i  (ipi_self_set),
    .other_set_i (ipi_other_set),
    .ack_i       (ipi_ack),
    .mset_i      (ipi_mset),
    .mclr_i      (ipi_mclr),
    .auto_mask_i (ipi_auto),
    .flag_o      (ipi_flag),
    .mask_o      (ipi_mask),
    .pend_o      (ipi_pend)
  );

  // event selection for the accessing processor
  logic [N_SRC-1:0] cur_pend;
  logic [1:0]       cur_ipi;
  logic             hw_found;
  logic [IDX_W-1:0] hw_idx;
  logic [31:0]      ev_data;

  assign cur_pend = src_pend[cpu_i];
  assign cur_ipi  = ipi_pend[cpu_i];

  autoack_intc_prio #(.W(N_SRC), .IW(IDX_W)) u_prio (
    .req_i   (cur_pend),
    .found_o (hw_found),
    .idx_o   (hw_idx)
  );

  always_comb begin
    ev_data = ev_word(EV_NONE, 16'd0);
    ipi_sel = 2'b00;
    hw_ack  = '0;
    if (cur_ipi[0]) begin
      ev_data = ev_word(EV_IPI, 16'd0);
      ipi_sel = 2'b01;
    end else if (cur_ipi[1]) begin
      ev_data = ev_word(EV_IPI, 16'd1);
      ipi_sel = 2'b10;
    end else if (hw_found) begin
      ev_data = ev_word(EV_HW, 16'(hw_idx));
      hw_ack  = evt_rd ? (N_SRC'(1) << hw_idx) : '0;
    end
  end

  // read mux
  logic [PAD_W-1:0] hw_pad, mask_pad, sw_pad;
  logic [31:0]      rd_d, rdata_q;
  assign hw_pad   = PAD_W'(irq_src_i);
  assign mask_pad = PAD_W'(src_mask);
  assign sw_pad   = PAD_W'(src_sw);

  always_comb begin
    rd_d = '0;
    for (int w = 0; w < int'(N_WORDS); w++) begin
      if (addr_i == A_HWST + 12'(w)) rd_d = hw_pad[w*32 +: 32];
      if (addr_i == A_MSET + 12'(w) || addr_i == A_MCLR + 12'(w)) rd_d = mask_pad[w*32 +: 32];
      if (addr_i == A_SSET + 12'(w) || addr_i == A_SCLR + 12'(w)) rd_d = sw_pad[w*32 +: 32];
    end
    for (int s = 0; s < int'(N_SRC); s++)
      if (addr_i == A_TGT + 12'(s)) rd_d = 32'(src_tgt[s]);
    unique case (addr_i)
      A_EVENT:                rd_d = ev_data;
      A_IPI_ACK:              rd_d = 32'(ipi_flag[cpu_i]);
      A_IPI_MSET, A_IPI_MCLR: rd_d = 32'(ipi_mask[cpu_i]);
      A_WHOAMI:               rd_d = 32'(cpu_i);
      default: ;
    endcase
  end

  logic [N_CPU-1:0] pend_any, irq_q;
  for (genvar c = 0; c < N_CPU; c++) begin : g_any
    assign pend_any[c] = (|src_pend[c]) | (|ipi_pend[c]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= '0;
    end else begin
      rdata_q <= rd ? rd_d : '0;
      irq_q   <= pend_any;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/autoack_intc_chk.sv
module autoack_intc_chk
  import autoack_intc_pkg::*;
#(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_CPU = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [11:0]      addr_i,
  input logic [31:0]      rdata_i,
  input logic [N_SRC-1:0] mask_i,
  input logic [N_CPU-1:0] pend_any_i,
  input logic [N_CPU-1:0] irq_i
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic evt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= req_i && !we_i && addr_i == A_EVENT;
  end

  // R6
  ack_masks_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && rdata_i[31:16] == 16'd1) |-> mask_i[rdata_i[IDX_W-1:0]]);

  // R10
  empty_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && rdata_i == 32'd0) |-> (mask_i == $past(mask_i)));

  // R8
  ipi_number_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && rdata_i[31:16] == 16'd4) |-> (rdata_i[15:0] <= 16'd1));

  // R5
  hw_number_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && rdata_i[31:16] == 16'd1) |-> (32'(rdata_i[15:0]) < N_SRC));

  for (genvar c = 0; c < N_CPU; c++) begin : g_irq
    // R12
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_any_i[c] |=> irq_i[c]);
    // R12
    irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_any_i[c] |=> !irq_i[c]);
  end
endmodule

bind autoack_intc autoack_intc_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_i    (rdata_o),
  .mask_i     (src_mask),
  .pend_any_i (pend_any),
  .irq_i      (irq_o)
);

// File: tb/tb_autoack_intc.sv
module tb_autoack_intc;
  localparam int N_SRC = 64;
  localparam int N_CPU = 2;
  localparam logic [63:0] HW = 64'h0000_0100_0000_0020;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_ni;
  logic [N_SRC-1:0] irq_src_i;
  logic             req_i, we_i;
  logic [11:0]      addr_i;
  logic [31:0]      wdata_i;
  logic             cpu_i;
  logic [31:0]      rdata_o;
  logic [N_CPU-1:0] irq_o;

  autoack_intc #(.N_SRC(N_SRC), .N_CPU(N_CPU)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_src_i(irq_src_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .cpu_i(cpu_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", rq, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with read data
  task automatic acc(input logic we, input logic [11:0] a, input logic [31:0] d,
                     input logic c, output logic [31:0] r);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; cpu_i = c;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
    r = rdata_o;
  endtask

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        cpu;
    logic [63:0] hw;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h010, 32'h0, 1'b0, 64'h0, 1'b1, 32'hFFFF_FFFF, 4'd1},  // R1
    '{1'b0, 12'h011, 32'h0, 1'b0, 64'h0, 1'b1, 32'hFFFF_FFFF, 4'd1},  // R1
    '{1'b0, 12'h105, 32'h0, 1'b0, 64'h0, 1'b1, 32'h1,         4'd1},  // R1
    '{1'b0, 12'h030, 32'h0, 1'b0, 64'h0, 1'b1, 32'h0,         4'd1},  // R1
    '{1'b0, 12'h200, 32'h0, 1'b0, 64'h0, 1'b1, 32'h0,         4'd10}, // R10
    '{1'b0, 12'h000, 32'h0, 1'b0, HW,    1'b1, 32'h20,        4'd2},  // R2
    '{1'b0, 12'h001, 32'h0, 1'b0, HW,    1'b1, 32'h100,       4'd2},  // R2
    '{1'b0, 12'h200, 32'h0, 1'b0, HW,    1'b1, 32'h0,         4'd2},  // R2 masked
    '{1'b1, 12'h020, 32'h20,  1'b0, HW,  1'b0, 32'h0,         4'd3},  // R3
    '{1'b1, 12'h021, 32'h100, 1'b0, HW,  1'b0, 32'h0,         4'd3},  // R3
    '{1'b1, 12'h010, 32'h0, 1'b0, HW,    1'b0, 32'h0,         4'd3},  // R3 zero write
    '{1'b0, 12'h010, 32'h0, 1'b0, HW,    1'b1, 32'hFFFF_FFDF, 4'd3},  // R3
    '{1'b0, 12'h021, 32'h0, 1'b0, HW,    1'b1, 32'hFFFF_FEFF, 4'd3},  // R3
    '{1'b0, 12'h200, 32'h0, 1'b0, HW,    1'b1, 32'h0001_0005, 4'd5},  // R5
    '{1'b0, 12'h010, 32'h0, 1'b0, HW,    1'b1, 32'hFFFF_FFFF, 4'd6},  // R6
    '{1'b0, 12'h200, 32'h0, 1'b0, HW,    1'b1, 32'h0001_0028, 4'd6},  // R6
    '{1'b0, 12'h200, 32'h0, 1'b0, HW,    1'b1, 32'h0,         4'd10}, // R10
    '{1'b0, 12'h011, 32'h0, 1'b0, HW,    1'b1, 32'hFFFF_FFFF, 4'd10}, // R10
    '{1'b1, 12'h030, 32'h8, 1'b0, 64'h0, 1'b0, 32'h0,         4'd4},  // R4
    '{1'b0, 12'h030, 32'h0, 1'b0, 64'h0, 1'b1, 32'h8,         4'd4},  // R4
    '{1'b1, 12'h020, 32'h8, 1'b0, 64'h0, 1'b0, 32'h0,         4'd7},
    '{1'b1, 12'h103, 32'h2, 1'b0, 64'h0, 1'b0, 32'h0,         4'd7},  // R7
    '{1'b0, 12'h103, 32'h0, 1'b0, 64'h0, 1'b1, 32'h2,         4'd7},  // R7
    '{1'b0, 12'h200, 32'h0, 1'b0, 64'h0, 1'b1, 32'h0,         4'd7},  // R7
    '{1'b0, 12'h200, 32'h0, 1'b1, 64'h0, 1'b1, 32'h0001_0003, 4'd7},  // R7
    '{1'b1, 12'h040, 32'h8, 1'b0, 64'h0, 1'b0, 32'h0,         4'd4},  // R4
    '{1'b0, 12'h030, 32'h0, 1'b0, 64'h0, 1'b1, 32'h0,         4'd4},  // R4
    '{1'b1, 12'h030, 32'h8, 1'b0, 64'h0, 1'b0, 32'h0,         4'd8},
    '{1'b1, 12'h020, 32'h8, 1'b0, 64'h0, 1'b0, 32'h0,         4'd8},
    '{1'b1, 12'h205, 32'h3, 1'b1, 64'h0, 1'b0, 32'h0,         4'd8},  // R8
    '{1'b1, 12'h202, 32'h2, 1'b0, 64'h0, 1'b0, 32'h0,         4'd8},  // R8
    '{1'b1, 12'h201, 32'h1, 1'b1, 64'h0, 1'b0, 32'h0,         4'd8},  // R8
    '{1'b0, 12'h203, 32'h0, 1'b0, 64'h0, 1'b1, 32'h0,         4'd8},  // R8
    '{1'b0, 12'h200, 32'h0, 1'b1, 64'h0, 1'b1, 32'h0004_0000, 4'd8},  // R8
    '{1'b0, 12'h200, 32'h0, 1'b1, 64'h0, 1'b1, 32'h0004_0001, 4'd8},  // R8
    '{1'b0, 12'h200, 32'h0, 1'b1, 64'h0, 1'b1, 32'h0001_0003, 4'd8},  // R8
    '{1'b0, 12'h203, 32'h0, 1'b1, 64'h0, 1'b1, 32'h3,         4'd9},  // R9
    '{1'b0, 12'h205, 32'h0, 1'b1, 64'h0, 1'b1, 32'h3,         4'd9},  // R9
    '{1'b1, 12'h203, 32'h3, 1'b1, 64'h0, 1'b0, 32'h0,         4'd8},  // R8
    '{1'b0, 12'h203, 32'h0, 1'b1, 64'h0, 1'b1, 32'h0,         4'd8},  // R8
    '{1'b0, 12'h206, 32'h0, 1'b1, 64'h0, 1'b1, 32'h1,         4'd11}, // R11
    '{1'b0, 12'h206, 32'h0, 1'b0, 64'h0, 1'b1, 32'h0,         4'd11}  // R11
  };

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_ni = 1'b0; irq_src_i = '0; req_i = 1'b0; we_i = 1'b0;
    addr_i = '0; wdata_i = '0; cpu_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1, 32'(irq_o), 32'h0); // R1

    for (int i = 0; i < NV; i++) begin
      irq_src_i = VEC[i].hw;
      acc(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].cpu, r);
      if (VEC[i].chk) chk(int'(VEC[i].rq), r, VEC[i].exp);
    end

    // reset mid-run restores every piece of state (R1)
    irq_src_i = '0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1, 32'(irq_o), 32'h0);        // R1
    acc(1'b0, 12'h204, 32'h0, 1'b0, r);
    chk(1, r, 32'h3);                 // R1 IPI masks
    acc(1'b0, 12'h103, 32'h0, 1'b0, r);
    chk(1, r, 32'h1);                 // R1 routing
    acc(1'b0, 12'h203, 32'h0, 1'b1, r);
    chk(1, r, 32'h0);                 // R1 IPI flags

    // output timing (R12) with a hardware level on source 7
    irq_src_i = 64'h80;
    acc(1'b1, 12'h020, 32'h80, 1'b0, r);
    chk(12, 32'(irq_o), 32'h0);       // R12 not yet
    @(negedge clk);
    chk(12, 32'(irq_o), 32'h1);       // R12 risen, CPU1 untouched (R7)
    acc(1'b0, 12'h200, 32'h0, 1'b0, r);
    chk(5, r, 32'h0001_0007);         // R5
    chk(12, 32'(irq_o), 32'h1);       // R12 still high at ack edge
    @(negedge clk);
    chk(12, 32'(irq_o), 32'h0);       // R12 fallen

    // level drop: a line that goes low is no longer reported (R2)
    acc(1'b1, 12'h020, 32'h80, 1'b0, r);
    irq_src_i = '0;
    acc(1'b0, 12'h200, 32'h0, 1'b0, r);
    chk(2, r, 32'h0);                 // R2
    chk(2, 32'(irq_o), 32'h0);        // R2

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule